// File: doc/BRIEF.md
# Tuner Synthesiser Serial Control Slave

This block is the serial control front end of a frequency synthesiser. It watches the two bus lines of an I2C bus, oversampling them with the system clock. It answers to one 7-bit device address, and the two lowest address bits come from a strapped select input. When addressed for writing, it loads a 15-bit divide ratio, a set of charge-pump and test controls, and six port enables. When addressed for reading, it returns a status byte. That byte carries a power-up flag, the lock flag, three port input levels and a 3-bit converter code.

The block has no register pointer. The top bit of each data byte says which pair it begins: 0 starts the frequency pair and 1 starts the control/port pair. The byte after that is always the second byte of the same pair. Any number of bytes may stream until a stop. A byte that is cut off before its eighth bit changes nothing. The power-up flag is set by reset and clears only at the stop that ends a transaction in which the device was read. Every control output is registered, and the bus data line is driven through an open-drain enable.

Top module: `tuner_ctrl_slave`

## Requirements
- R1: The device responds to the address bits 1,1,0,0,0,S1,S0 (MSB first, S1:S0 = addr_sel_i) followed by a read/write bit, 1 = read. On a match it pulls SDA low in the acknowledge slot. On any other address it neither acknowledges nor acknowledges the bytes that follow, and it changes no output.
- R2: In write mode a data byte whose MSB is 0 loads div_ratio_o[14:8] from its bits 6..0. The next byte loads div_ratio_o[7:0]. Each data byte is acknowledged.
- R3: In write mode a data byte whose MSB is 1 loads cp_high_o from bit 6, test_route_o from bit 5, pump_off_o from bit 4 and drive_off_o from bit 0. Bits 3..1 are ignored.
- R4: The byte after a control byte sets port_on_o = {b7,b6,b5,b4,b3,b0}, which is {P7,P6,P5,P4,P3,P0}. A 1 turns a port on. Bits 2..1 are ignored.
- R5: Data bytes may keep streaming without a new address until a stop. After each pair completes, the next byte picks its pair again by its MSB.
- R6: A byte that ends (through a stop or a start) before its eighth bit leaves every output unchanged.
- R7: In read mode the device sends the byte {POR, lock_i, port_lvl_i[2:0], adc_code_i[2:0]} MSB first. port_lvl_i is ordered {P7,P5,P4}.
- R8: In read mode the status byte is sent again after each master acknowledge. After a master not-acknowledge the device releases SDA.
- R9: POR reads 1 after reset. It becomes 0 at the stop that ends a transaction in which the device was addressed for reading. A stop after a write-only transaction leaves it unchanged.
- R10: After reset, div_ratio_o, all control bits and port_on_o are 0, and sda_oe_o is 0.
- R11: A repeated start discards any transfer in progress and restarts address decoding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| addr_sel_i | input | 2 | Strapped low address bits S1:S0 |
| lock_i | input | 1 | Synthesiser lock flag |
| port_lvl_i | input | 3 | Port input levels {P7,P5,P4} |
| adc_code_i | input | 3 | 3-bit converter code |
| sda_oe_o | output | 1 | 1 pulls the data line low |
| div_ratio_o | output | 15 | Programmed divide ratio |
| cp_high_o | output | 1 | High charge-pump current |
| test_route_o | output | 1 | Phase comparator test routing |
| pump_off_o | output | 1 | Charge pump disable |
| drive_off_o | output | 1 | Drive amplifier disable |
| port_on_o | output | 6 | Port enables {P7,P6,P5,P4,P3,P0} |

## Verification
A bus edge reaches the engine SYNC_STAGES+1 system cycles after it appears at the pins. A register output changes one cycle after the engine sees the falling SCL edge that closes the byte's eighth bit, and acknowledge or read data appear on sda_oe_o at that same point. The bench master holds each SCL phase for eight system cycles. It samples the data line only in the last cycle of SCL high, well after the slave's drive has settled. It checks register outputs only after a stop and a further settling wait, so every comparison falls after the latest possible update.

// File: rtl/tsc_pkg.sv
package tsc_pkg;
    localparam logic [4:0] DEV_ID = 5'b11000;

    typedef enum logic [1:0] {
        K_FHI,
        K_FLO,
        K_CTRL,
        K_PORT
    } wr_kind_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_AACK,
        ST_WDATA,
        ST_DACK,
        ST_TX,
        ST_RACK,
        ST_IGNORE
    } eng_st_e;
endpackage

// File: rtl/tsc_sync.sv
module tsc_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_ev,
    output logic stop_ev
);
    localparam int LINES = 2;

    logic [LINES-1:0] raw;
    logic [LINES-1:0] sy;
    logic [LINES-1:0] prev_d, prev_q;

    assign raw = {scl_i, sda_i};

    genvar g;
    for (g = 0; g < LINES; g++) begin : g_line
        logic [STAGES-1:0] ch_d, ch_q;
        always_comb ch_d = {ch_q[STAGES-2:0], raw[g]};
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) ch_q <= '1;
            else        ch_q <= ch_d;
        end
        assign sy[g] = ch_q[STAGES-1];
    end

    always_comb prev_d = sy;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '1;
        else        prev_q <= prev_d;
    end

    assign scl_s    = sy[1];
    assign sda_s    = sy[0];
    assign scl_rise = sy[1] & ~prev_q[1];
    assign scl_fall = ~sy[1] & prev_q[1];
    assign start_ev = sy[1] & prev_q[1] & prev_q[0] & ~sy[0];
    assign stop_ev  = sy[1] & prev_q[1] & ~prev_q[0] & sy[0];
endmodule

// File: rtl/tsc_engine.sv
module tsc_engine
    import tsc_pkg::*;
#(
    parameter int BYTE_W = 8,
    parameter int SEL_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              sda_s,
    input  logic              start_ev,
    input  logic              stop_ev,
    input  logic [SEL_W-1:0]  addr_sel,
    input  logic [BYTE_W-1:0] status,
    output logic              sda_oe,
    output logic              wr_vld,
    output wr_kind_e          wr_kind,
    output logic [BYTE_W-1:0] wr_data,
    output logic              por_clr
);
    localparam int CNT_W = $clog2(BYTE_W + 1);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_W);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W - 1);

    typedef struct packed {
        eng_st_e           st;
        logic [CNT_W-1:0]  cnt;
        logic [BYTE_W-1:0] sh;
        logic [BYTE_W-1:0] tx;
        logic              sda_oe;
        logic              rw;
        logic              second;
        logic              pair;
        logic              rd_seen;
        logic              mnack;
    } eng_t;

    eng_t d, q;
    logic addr_hit;

    assign addr_hit = (q.sh[BYTE_W-1:1] == {DEV_ID, addr_sel});

    always_comb begin
        d       = q;
        wr_vld  = 1'b0;
        wr_kind = K_FHI;
        wr_data = q.sh;
        por_clr = 1'b0;
        if (stop_ev) begin
            d.st      = ST_IDLE;
            d.sda_oe  = 1'b0;
            por_clr   = q.rd_seen;
            d.rd_seen = 1'b0;
        end else if (start_ev) begin
            d.st     = ST_ADDR;
            d.cnt    = '0;
            d.sda_oe = 1'b0;
        end else begin
            case (q.st)
                ST_ADDR, ST_WDATA: begin
                    if (scl_rise && q.cnt < FULL) begin
                        d.sh  = {q.sh[BYTE_W-2:0], sda_s};
                        d.cnt = q.cnt + 1'b1;
                    end else if (scl_fall && q.cnt == FULL) begin
                        if (q.st == ST_ADDR) begin
                            if (addr_hit) begin
                                d.rw      = q.sh[0];
                                d.rd_seen = q.rd_seen | q.sh[0];
                                d.second  = 1'b0;
                                d.sda_oe  = 1'b1;
                                d.st      = ST_AACK;
                            end else begin
                                d.st = ST_IGNORE;
                            end
                        end else begin
                            wr_vld = 1'b1;
                            if (!q.second) begin
                                wr_kind  = q.sh[BYTE_W-1] ? K_CTRL : K_FHI;
                                d.pair   = q.sh[BYTE_W-1];
                                d.second = 1'b1;
                            end else begin
                                wr_kind  = q.pair ? K_PORT : K_FLO;
                                d.second = 1'b0;
                            end
                            d.sda_oe = 1'b1;
                            d.st     = ST_DACK;
                        end
                    end
                end
                ST_AACK: begin
                    if (scl_fall) begin
                        d.cnt = '0;
                        if (q.rw) begin
                            d.tx     = status;
                            d.sda_oe = ~status[BYTE_W-1];
                            d.st     = ST_TX;
                        end else begin
                            d.sda_oe = 1'b0;
                            d.st     = ST_WDATA;
                        end
                    end
                end
                ST_DACK: begin
                    if (scl_fall) begin
                        d.sda_oe = 1'b0;
                        d.cnt    = '0;
                        d.st     = ST_WDATA;
                    end
                end
                ST_TX: begin
                    if (scl_fall) begin
                        if (q.cnt == LAST) begin
                            d.sda_oe = 1'b0;
                            d.st     = ST_RACK;
                        end else begin
                            d.tx     = {q.tx[BYTE_W-2:0], 1'b0};
                            d.sda_oe = ~q.tx[BYTE_W-2];
                            d.cnt    = q.cnt + 1'b1;
                        end
                    end
                end
                ST_RACK: begin
                    if (scl_rise) begin
                        d.mnack = sda_s;
                    end else if (scl_fall) begin
                        if (q.mnack) begin
                            d.st = ST_IGNORE;
                        end else begin
                            d.tx     = status;
                            d.sda_oe = ~status[BYTE_W-1];
                            d.cnt    = '0;
                            d.st     = ST_TX;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q         <= '0;
            q.st      <= ST_IDLE;
        end else begin
            q <= d;
        end
    end

    assign sda_oe = q.sda_oe;

    // R10
    idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_IDLE) |-> !q.sda_oe);

    // R8
    ignore_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_IGNORE) |-> !q.sda_oe);

    // R9
    stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_ev |=> !q.sda_oe);

    // R6
    bitcnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.cnt <= FULL);
endmodule

// File: rtl/tsc_regs.sv
module tsc_regs
    import tsc_pkg::*;
#(
    parameter int DIV_W  = 15,
    parameter int BYTE_W = 8,
    parameter int PORT_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_vld,
    input  wr_kind_e          wr_kind,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              por_clr,
    output logic [DIV_W-1:0]  div_ratio,
    output logic              cp_high,
    output logic              test_route,
    output logic              pump_off,
    output logic              drive_off,
    output logic [PORT_W-1:0] port_on,
    output logic              por
);
    localparam int HI_W = DIV_W - BYTE_W;

    typedef struct packed {
        logic [DIV_W-1:0]  div;
        logic              cp;
        logic              tst;
        logic              poff;
        logic              doff;
        logic [PORT_W-1:0] ports;
        logic              por;
    } regs_t;

    regs_t d, q;

    always_comb begin
        d = q;
        if (wr_vld) begin
            case (wr_kind)
                K_FHI:  d.div[DIV_W-1:BYTE_W] = wr_data[HI_W-1:0];
                K_FLO:  d.div[BYTE_W-1:0]     = wr_data;
                K_CTRL: begin
                    d.cp   = wr_data[6];
                    d.tst  = wr_data[5];
                    d.poff = wr_data[4];
                    d.doff = wr_data[0];
                end
                default: d.ports = {wr_data[7:3], wr_data[0]};
            endcase
        end
        if (por_clr) d.por = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q     <= '0;
            q.por <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign div_ratio  = q.div;
    assign cp_high    = q.cp;
    assign test_route = q.tst;
    assign pump_off   = q.poff;
    assign drive_off  = q.doff;
    assign port_on    = q.ports;
    assign por        = q.por;

    // R9
    por_norise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$rose(q.por));

    // R6
    div_only_on_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(q.div) |-> $past(wr_vld));

    // R4
    ports_only_on_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(q.ports) |-> $past(wr_vld));
endmodule

// File: rtl/tuner_ctrl_slave.sv
module tuner_ctrl_slave
    import tsc_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int DIV_W       = 15,
    parameter int PORT_W      = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    input  logic [1:0]        addr_sel_i,
    input  logic              lock_i,
    input  logic [2:0]        port_lvl_i,
    input  logic [2:0]        adc_code_i,
    output logic              sda_oe_o,
    output logic [DIV_W-1:0]  div_ratio_o,
    output logic              cp_high_o,
    output logic              test_route_o,
    output logic              pump_off_o,
    output logic              drive_off_o,
    output logic [PORT_W-1:0] port_on_o
);
    localparam int BYTE_W = 8;

    logic scl_s, sda_s, scl_rise, scl_fall, start_ev, stop_ev;
    logic wr_vld, por_clr, por;
    wr_kind_e wr_kind;
    logic [BYTE_W-1:0] wr_data, status;

    assign status = {por, lock_i, port_lvl_i, adc_code_i};

    tsc_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl_i),
        .sda_i    (sda_i),
        .scl_s    (scl_s),
        .sda_s    (sda_s),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_ev (start_ev),
        .stop_ev  (stop_ev)
    );

    tsc_engine #(.BYTE_W(BYTE_W), .SEL_W(2)) u_eng (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .sda_s    (sda_s),
        .start_ev (start_ev),
        .stop_ev  (stop_ev),
        .addr_sel (addr_sel_i),
        .status   (status),
        .sda_oe   (sda_oe_o),
        .wr_vld   (wr_vld),
        .wr_kind  (wr_kind),
        .wr_data  (wr_data),
        .por_clr  (por_clr)
    );

    tsc_regs #(.DIV_W(DIV_W), .BYTE_W(BYTE_W), .PORT_W(PORT_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_vld     (wr_vld),
        .wr_kind    (wr_kind),
        .wr_data    (wr_data),
        .por_clr    (por_clr),
        .div_ratio  (div_ratio_o),
        .cp_high    (cp_high_o),
        .test_route (test_route_o),
        .pump_off   (pump_off_o),
        .drive_off  (drive_off_o),
        .port_on    (port_on_o),
        .por        (por)
    );

    // R1
    no_drive_in_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_ev |=> !sda_oe_o);
endmodule

// File: tb/tb_tuner_ctrl_slave.sv
module tb_tuner_ctrl_slave;
    localparam int HALF = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic [1:0] addr_sel = 2'b10;
    logic lock = 1'b1;
    logic [2:0] port_lvl = 3'b101;
    logic [2:0] adc = 3'b011;
    logic sda_oe;
    logic [14:0] div_ratio;
    logic cp_high, test_route, pump_off, drive_off;
    logic [5:0] port_on;
    logic sda_line;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    assign sda_line = sda_m & ~sda_oe;

    always #10 clk = ~clk;

    tuner_ctrl_slave dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .scl_i        (scl_m),
        .sda_i        (sda_line),
        .addr_sel_i   (addr_sel),
        .lock_i       (lock),
        .port_lvl_i   (port_lvl),
        .adc_code_i   (adc),
        .sda_oe_o     (sda_oe),
        .div_ratio_o  (div_ratio),
        .cp_high_o    (cp_high),
        .test_route_o (test_route),
        .pump_off_o   (pump_off),
        .drive_off_o  (drive_off),
        .port_on_o    (port_on)
    );

    typedef enum int {F_DIV, F_CP, F_TST, F_POFF, F_DOFF, F_PORTS, F_OE} field_e;
    typedef struct {
        string  req;
        field_e fld;
        int     exp;
    } item_t;

    item_t sbq[$];

    task automatic check(input string req, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s got %0h exp %0h", req, got, exp);
        end
    endtask

    function automatic int observe(input field_e f);
        case (f)
            F_DIV:   return int'(div_ratio);
            F_CP:    return int'(cp_high);
            F_TST:   return int'(test_route);
            F_POFF:  return int'(pump_off);
            F_DOFF:  return int'(drive_off);
            F_PORTS: return int'(port_on);
            default: return int'(sda_oe);
        endcase
    endfunction

    task automatic expect_out(input string req, input field_e f, input int exp);
        item_t it;
        it.req = req;
        it.fld = f;
        it.exp = exp;
        sbq.push_back(it);
    endtask

    // monitor: pops expected items and compares against the outputs
    initial begin
        forever begin
            item_t it;
            wait (sbq.size() != 0);
            it = sbq.pop_front();
            check(it.req, observe(it.fld), it.exp);
        end
    end

    task automatic wc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_bit(input logic b);
        sda_m = b;
        wc(HALF);
        scl_m = 1'b1;
        wc(HALF);
        scl_m = 1'b0;
        wc(4);
    endtask

    task automatic recv_bit(output logic b);
        sda_m = 1'b1;
        wc(HALF);
        scl_m = 1'b1;
        wc(HALF - 1);
        b = sda_line;
        wc(1);
        scl_m = 1'b0;
        wc(4);
    endtask

    task automatic bus_start();
        sda_m = 1'b1;
        scl_m = 1'b1;
        wc(HALF);
        sda_m = 1'b0;
        wc(HALF);
        scl_m = 1'b0;
        wc(4);
    endtask

    task automatic bus_rstart();
        sda_m = 1'b1;
        wc(HALF);
        scl_m = 1'b1;
        wc(HALF);
        sda_m = 1'b0;
        wc(HALF);
        scl_m = 1'b0;
        wc(4);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0;
        wc(HALF);
        scl_m = 1'b1;
        wc(HALF);
        sda_m = 1'b1;
        wc(3 * HALF);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
        recv_bit(ack);
    endtask

    task automatic read_byte(input logic mnack, output logic [7:0] v);
        for (int i = 7; i >= 0; i--) begin
            logic bt;
            recv_bit(bt);
            v[i] = bt;
        end
        send_bit(mnack);
    endtask

    task automatic wr_chk(input string req, input logic [7:0] b, input logic exp_ack);
        logic a;
        send_byte(b, a);
        check(req, int'(a), int'(exp_ack));
    endtask

    task automatic rd_chk(input string req, input logic mnack, input logic [7:0] exp);
        logic [7:0] v;
        read_byte(mnack, v);
        check(req, int'(v), int'(exp));
    endtask

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        wc(5);
        rst_n = 1'b1;
        wc(5);

        // R10: reset state
        expect_out("R10 div", F_DIV, 0);
        expect_out("R10 cp", F_CP, 0);
        expect_out("R10 tst", F_TST, 0);
        expect_out("R10 poff", F_POFF, 0);
        expect_out("R10 doff", F_DOFF, 0);
        expect_out("R10 ports", F_PORTS, 0);
        expect_out("R10 oe", F_OE, 0);

        // R2: frequency pair
        bus_start();
        wr_chk("R1 addr ack", 8'hC4, 1'b0);
        wr_chk("R2 byte2 ack", 8'h2A, 1'b0);
        wr_chk("R2 byte3 ack", 8'h5C, 1'b0);
        bus_stop();
        expect_out("R2 div", F_DIV, 15'h2A5C);

        // R7, R9: POR still 1 after a write-only stop; R8 repeat on ack
        bus_start();
        wr_chk("R1 read addr ack", 8'hC5, 1'b0);
        rd_chk("R7 status por1", 1'b0, 8'hEB);
        rd_chk("R8 status repeat", 1'b1, 8'hEB);
        wc(4);
        expect_out("R8 release after nack", F_OE, 0);
        bus_stop();

        // R9: POR cleared by stop after read
        port_lvl = 3'b010;
        adc = 3'b100;
        lock = 1'b0;
        bus_start();
        wr_chk("R1 read addr ack2", 8'hC5, 1'b0);
        rd_chk("R9 por cleared", 1'b1, 8'h14);
        bus_stop();
        lock = 1'b1;
        port_lvl = 3'b101;
        adc = 3'b011;

        // R3, R4: control pair
        bus_start();
        wr_chk("R1 addr ack3", 8'hC4, 1'b0);
        wr_chk("R3 byte4 ack", 8'hDF, 1'b0);
        wr_chk("R4 byte5 ack", 8'hB1, 1'b0);
        bus_stop();
        expect_out("R3 cp", F_CP, 1);
        expect_out("R3 tst", F_TST, 0);
        expect_out("R3 poff", F_POFF, 1);
        expect_out("R3 doff", F_DOFF, 1);
        expect_out("R4 ports", F_PORTS, 6'b101101);
        expect_out("R3 div kept", F_DIV, 15'h2A5C);

        // R5: streaming, pair chosen per byte
        bus_start();
        wr_chk("R5 addr", 8'hC4, 1'b0);
        wr_chk("R5 f hi", 8'h01, 1'b0);
        wr_chk("R5 f lo", 8'h02, 1'b0);
        wc(10);
        expect_out("R5 div mid", F_DIV, 15'h0102);
        wr_chk("R5 ctrl", 8'hA0, 1'b0);
        wr_chk("R5 port", 8'h08, 1'b0);
        wr_chk("R5 f hi2", 8'h7F, 1'b0);
        wr_chk("R5 f lo2", 8'hFF, 1'b0);
        bus_stop();
        expect_out("R5 cp", F_CP, 0);
        expect_out("R5 tst", F_TST, 1);
        expect_out("R5 poff", F_POFF, 0);
        expect_out("R5 ports", F_PORTS, 6'b000010);
        expect_out("R5 div", F_DIV, 15'h7FFF);

        // R6: truncated second byte, then truncated first byte
        bus_start();
        wr_chk("R6 addr", 8'hC4, 1'b0);
        wr_chk("R6 f hi", 8'h00, 1'b0);
        for (int i = 0; i < 4; i++) send_bit(1'b0);
        bus_stop();
        expect_out("R6 lo kept", F_DIV, 15'h00FF);
        bus_start();
        wr_chk("R6 addr2", 8'hC4, 1'b0);
        for (int i = 0; i < 7; i++) send_bit(1'b1);
        bus_stop();
        expect_out("R6 ctrl kept", F_TST, 1);
        expect_out("R6 ports kept", F_PORTS, 6'b000010);

        // R1: wrong address ignored
        bus_start();
        wr_chk("R1 wrong addr nack", 8'hC0, 1'b1);
        wr_chk("R1 data nack", 8'h11, 1'b1);
        wr_chk("R1 data nack2", 8'h22, 1'b1);
        bus_stop();
        expect_out("R1 div unchanged", F_DIV, 15'h00FF);

        // R11: repeated start restarts decoding
        bus_start();
        wr_chk("R11 wrong first", 8'hC0, 1'b1);
        bus_rstart();
        wr_chk("R11 addr after rstart", 8'hC4, 1'b0);
        wr_chk("R11 f hi", 8'h03, 1'b0);
        for (int i = 0; i < 3; i++) send_bit(1'b1);
        bus_rstart();
        wr_chk("R11 addr again", 8'hC4, 1'b0);
        wr_chk("R11 f hi2", 8'h03, 1'b0);
        wr_chk("R11 f lo", 8'h04, 1'b0);
        bus_rstart();
        wr_chk("R11 read addr", 8'hC5, 1'b0);
        rd_chk("R11 status", 1'b1, 8'h6B);
        bus_stop();
        expect_out("R11 div", F_DIV, 15'h0304);

        wait (sbq.size() == 0);
        wc(2);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule